// File: doc/BRIEF.md
# SD card clock prescaler/divisor selector

This block turns a write of the standard 16-bit SD host clock-control halfword into the two-stage clock fields of a vendor clock register. That register has a power-of-two prescaler and a linear divisor of 1 to 16. The block first recovers the requested card-clock frequency from the standard divider code. In legacy (version 2.0) mode the code selects base / 2^N. In extended (version 3.0) mode it selects base / 2N, with a 10-bit N. The block then searches for the smallest prescaler, and after that the smallest divisor, whose output frequency does not exceed the request. The result goes into the vendor register as zero-based fields.

Writes enter on a valid/ready channel. The producer holds `wr_valid` and `wr_data` until `wr_ready` is high. A write with the card-clock enable set starts the computation and drops `wr_ready` until the register update, which is marked by a one-cycle `upd_done`. A write with the enable clear finishes in its own cycle and leaves `wr_ready` high. Readback presents the standard-format halfword built from the cached divider bits and the status bits. The base frequency in Hz and the mode are taken in the accept cycle.

Top module: `sdclk_divsel`

## Requirements
- R1: Out of reset, `clk_reg` equals parameter RESET_VAL (default 0x00A5000C), `wr_ready` is 1, `upd_done` is 0 and the readback divider bits are 0.
- R2: In legacy mode (`v3_mode`=0) the requested frequency is base >> n. Here n is the 1-based position of the lowest set bit in `wr_data[15:8]`, and a zero byte requests the base itself. `wr_data[7:6]` have no effect.
- R3: In extended mode (`v3_mode`=1) the divider is N = {`wr_data[7:6]`, `wr_data[15:8]`}. N = 0 requests the base, and any other N requests floor(base / 2N).
- R4: The prescaler p is the smallest power of two, at least 2, for which the request is not below floor(base / (16p)).
- R5: With that p, the divisor d is the smallest d ≥ 1 for which the request is not below floor(base / (p·d)). As a result, floor(base / (p·d)) never exceeds the request.
- R6: When an enabled write completes, `clk_reg[15:8]` holds p/2, `clk_reg[7:4]` holds d−1 and `clk_reg[0]` is set. Bits 31:16 and 3:1 keep their value, and `upd_done` pulses for one cycle in the same cycle the register changes.
- R7: A legacy-mode write with the card-clock enable (`wr_data[2]`) clear clears `clk_reg[3]` on the next edge, leaves every other bit unchanged, produces no `upd_done` and keeps `wr_ready` high.
- R8: An extended-mode write with `wr_data[2]` clear leaves `clk_reg` unchanged and produces no `upd_done`.
- R9: `rd_clkctl` shows bits 15:6 of the last accepted write, whether enabled or not. Bit 0 and bit 2 read 1, bit 1 follows `clk_stable`, and bits 5:3 read 0.
- R10: After an enabled write is accepted, `wr_ready` stays low until the cycle of its `upd_done`. A write offered during that time is not taken and does not change the readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Clock-control write offered |
| wr_ready | output | 1 | Block can take a write |
| wr_data | input | 16 | Standard clock-control halfword |
| v3_mode | input | 1 | 1: extended divider scheme, 0: legacy power-of-two scheme |
| base_hz | input | BASE_W | Base clock frequency in Hz |
| clk_stable | input | 1 | Internal clock stable flag from present state |
| clk_reg | output | 32 | Vendor clock register |
| upd_done | output | 1 | One-cycle pulse when clk_reg takes new fields |
| rd_clkctl | output | 16 | Standard-format readback |

## Verification
Legacy codes are swept over every single-bit divider byte, a zero byte and bytes with several bits set. The multi-bit bytes separate a lowest-bit decode from a highest-bit one, and the high bits 7:6 are set to show they are ignored. Extended codes sweep small N, N values that only the upper two bits carry, and the maximum N, which separates the 10-bit assembly and the zero case from a plain 8-bit divide. Both sweeps run over bases from zero and one up to the all-ones value. Odd bases exercise the truncating divisions, where a correct search and an off-by-one search give different fields. Each result is also checked against the bound floor(base/(p·d)) ≤ request. Disabled writes in both modes and a write offered during a busy computation show the differences in hold-off and preservation behaviour.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  localparam logic [15:0] DIVBITS_MASK = 16'hFFC0;
  localparam int CARD_EN_BIT  = 2;
  localparam int CLK_ON_BIT   = 3;
  localparam int PRE_CODE_W   = 8;
  localparam int DIV_CODE_W   = 4;
  localparam int DIV_MAX      = 16;
  localparam int MDIV_W       = 11;
  localparam logic [15:0] RD_FIXED = 16'h0005;

  typedef enum logic [1:0] {T_IDLE, T_DIV, T_SRCH} top_st_t;
  typedef enum logic [1:0] {S_IDLE, S_PRE, S_DVS} srch_st_t;
endpackage

// File: rtl/sdclk_freq_decode.sv
module sdclk_freq_decode
  import sdclk_pkg::*;
(
  input  logic [9:0]        divbits,
  input  logic              v3_mode,
  output logic [MDIV_W-1:0] mdiv
);
  logic [7:0]        lo_byte;
  logic [9:0]        n10;
  logic [3:0]        idx;
  logic              hit;
  logic [MDIV_W-1:0] m_v2;
  logic [MDIV_W-1:0] m_v3;

  assign lo_byte = divbits[9:2];
  assign n10     = {divbits[1:0], divbits[9:2]};

  always_comb begin
    idx = '0;
    hit = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      if (lo_byte[i]) begin
        idx = 4'(i + 1);
        hit = 1'b1;
      end
    end
  end

  assign m_v2 = hit ? (MDIV_W'(1) << idx) : MDIV_W'(1);
  assign m_v3 = (n10 == '0) ? MDIV_W'(1) : {n10, 1'b0};
  assign mdiv = v3_mode ? m_v3 : m_v2;
endmodule

// File: rtl/sdclk_serial_div.sv
module sdclk_serial_div #(
  parameter int NUM_W = 32,
  parameter int DEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quo
);
  localparam int CNT_W = $clog2(NUM_W + 1);
  localparam int PW    = NUM_W + DEN_W + 1;

  logic [DEN_W-1:0] rem_q;
  logic [NUM_W-1:0] sh_q;
  logic [NUM_W-1:0] num_q;
  logic [DEN_W-1:0] den_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             done_q;
  logic [DEN_W:0]   trial;
  logic [DEN_W:0]   diff;
  logic             ge;

  assign trial = {rem_q, sh_q[NUM_W-1]};
  assign ge    = trial >= {1'b0, den_q};
  assign diff  = trial - {1'b0, den_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q  <= '0;
      sh_q   <= '0;
      num_q  <= '0;
      den_q  <= DEN_W'(1);
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        rem_q <= '0;
        sh_q  <= num;
        num_q <= num;
        den_q <= den;
        cnt_q <= CNT_W'(NUM_W);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= ge ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
        sh_q  <= {sh_q[NUM_W-2:0], ge};
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done = done_q;
  assign quo  = sh_q;

  // Quotient is the exact floor of the decoded request (R3)
  p_quo_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ((PW'(sh_q) * PW'(den_q) <= PW'(num_q)) &&
                ((PW'(sh_q) + PW'(1)) * PW'(den_q) > PW'(num_q))));
endmodule

// File: rtl/sdclk_presc_search.sv
module sdclk_presc_search
  import sdclk_pkg::*;
#(
  parameter int F_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [F_W-1:0]        freq,
  input  logic [F_W-1:0]        base,
  output logic                  done,
  output logic [PRE_CODE_W-1:0] pre_code,
  output logic [DIV_CODE_W-1:0] div_code
);
  localparam int P_W  = PRE_CODE_W + 1;
  localparam int D_W  = DIV_CODE_W + 1;
  localparam int K_W  = P_W + D_W;
  localparam int PR_W = F_W + 1 + K_W;

  srch_st_t       st_q;
  logic [P_W-1:0] p_q;
  logic [D_W-1:0] d_q;
  logic           done_q;
  logic [K_W-1:0] k;
  logic [F_W:0]   f1;
  logic [PR_W-1:0] prod;
  logic           fits;

  assign k    = (st_q == S_PRE) ? K_W'({p_q, 4'b0000}) : K_W'(p_q) * K_W'(d_q);
  assign f1   = {1'b0, freq} + (F_W + 1)'(1);
  assign prod = PR_W'(f1) * PR_W'(k);
  assign fits = prod <= PR_W'(base);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      p_q    <= P_W'(2);
      d_q    <= D_W'(1);
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        S_IDLE: if (start) begin
          p_q  <= P_W'(2);
          d_q  <= D_W'(1);
          st_q <= S_PRE;
        end
        S_PRE: begin
          if (fits && !p_q[P_W-1]) begin
            p_q <= p_q << 1;
          end else begin
            d_q  <= D_W'(1);
            st_q <= S_DVS;
          end
        end
        S_DVS: begin
          if (fits && (d_q < D_W'(DIV_MAX))) begin
            d_q <= d_q + D_W'(1);
          end else begin
            done_q <= 1'b1;
            st_q   <= S_IDLE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign done     = done_q;
  assign pre_code = p_q[P_W-1:1];
  assign div_code = DIV_CODE_W'(d_q - D_W'(1));

  // Prescaler search restarts at 2 and stays a power of two (R4)
  p_pre_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && st_q == S_IDLE) |=> (p_q == P_W'(2)));
  p_pre_pow2_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != S_IDLE) |-> $onehot(p_q));
  // Divisor stays within 1..16 (R5)
  p_div_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_DVS) |-> (d_q >= D_W'(1) && d_q <= D_W'(DIV_MAX)));
endmodule

// File: rtl/sdclk_divsel.sv
module sdclk_divsel
  import sdclk_pkg::*;
#(
  parameter int          BASE_W    = 32,
  parameter logic [31:0] RESET_VAL = 32'h00A5_000C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [15:0]       wr_data,
  input  logic              v3_mode,
  input  logic [BASE_W-1:0] base_hz,
  input  logic              clk_stable,
  output logic [31:0]       clk_reg,
  output logic              upd_done,
  output logic [15:0]       rd_clkctl
);
  top_st_t                 st_q;
  logic [15:0]             cache_q;
  logic [31:0]             reg_q;
  logic                    done_q;
  logic [BASE_W-1:0]       base_q;
  logic                    accept;
  logic                    card_en;
  logic                    div_start;
  logic [MDIV_W-1:0]       mdiv;
  logic                    div_done;
  logic [BASE_W-1:0]       freq;
  logic                    srch_done;
  logic [PRE_CODE_W-1:0]   pre_code;
  logic [DIV_CODE_W-1:0]   div_code;

  assign wr_ready  = (st_q == T_IDLE);
  assign accept    = wr_valid && wr_ready;
  assign card_en   = wr_data[CARD_EN_BIT];
  assign div_start = accept && card_en;

  sdclk_freq_decode u_decode (
    .divbits (wr_data[15:6]),
    .v3_mode (v3_mode),
    .mdiv    (mdiv)
  );

  sdclk_serial_div #(.NUM_W(BASE_W), .DEN_W(MDIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start),
    .num   (base_hz),
    .den   (mdiv),
    .done  (div_done),
    .quo   (freq)
  );

  sdclk_presc_search #(.F_W(BASE_W)) u_search (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_done),
    .freq     (freq),
    .base     (base_q),
    .done     (srch_done),
    .pre_code (pre_code),
    .div_code (div_code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= T_IDLE;
      cache_q <= '0;
      reg_q   <= RESET_VAL;
      done_q  <= 1'b0;
      base_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        T_IDLE: if (accept) begin
          cache_q <= wr_data & DIVBITS_MASK;
          if (card_en) begin
            base_q <= base_hz;
            st_q   <= T_DIV;
          end else if (!v3_mode) begin
            reg_q[CLK_ON_BIT] <= 1'b0;
          end
        end
        T_DIV: if (div_done) st_q <= T_SRCH;
        T_SRCH: if (srch_done) begin
          reg_q  <= {reg_q[31:16], pre_code, div_code, reg_q[3:1], 1'b1};
          done_q <= 1'b1;
          st_q   <= T_IDLE;
        end
        default: st_q <= T_IDLE;
      endcase
    end
  end

  assign clk_reg   = reg_q;
  assign upd_done  = done_q;
  assign rd_clkctl = cache_q | RD_FIXED | {14'b0, clk_stable, 1'b0};

  // Completed update sets bit 0 and keeps the upper half (R6)
  p_update_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |-> (clk_reg[0] && (clk_reg[31:16] == $past(clk_reg[31:16]))));
  // Disabled legacy write clears the clock-on bit (R7)
  p_v2_off_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !card_en && !v3_mode) |=> (!clk_reg[CLK_ON_BIT] && !upd_done));
  // Disabled extended write leaves the register alone (R8)
  p_v3_off_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !card_en && v3_mode) |=> ($stable(clk_reg) && !upd_done));
  // Enabled write holds off the channel (R10)
  p_busy_holdoff_r10: assert property (@(posedge clk) disable iff (!rst_n)
    div_start |=> !wr_ready);
  p_cache_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |=> $stable(rd_clkctl[15:6]));
endmodule

// File: tb/tb_sdclk_divsel.sv
module tb_sdclk_divsel;
  localparam logic [31:0] RST_VAL = 32'h00A5_000C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [15:0] wr_data = '0;
  logic        v3_mode = 1'b0;
  logic [31:0] base_hz = '0;
  logic        clk_stable = 1'b0;
  logic [31:0] clk_reg;
  logic        upd_done;
  logic [15:0] rd_clkctl;

  int checks = 0;
  int errors = 0;
  logic [31:0] mreg;
  logic [15:0] mcache;

  logic [31:0] q_reg[$];
  logic [31:0] q_freq[$];
  logic [31:0] q_base[$];
  bit          q_v3[$];

  always #4 clk = ~clk;

  sdclk_divsel #(.BASE_W(32), .RESET_VAL(RST_VAL)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .v3_mode(v3_mode), .base_hz(base_hz),
    .clk_stable(clk_stable), .clk_reg(clk_reg), .upd_done(upd_done),
    .rd_clkctl(rd_clkctl)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_freq(input logic [31:0] b, input bit v3, input logic [15:0] v);
    logic [9:0] n;
    n = {v[7:6], v[15:8]};
    if (v3) return (n == 0) ? b : 32'(longint'(b) / (longint'(n) * 2));
    for (int i = 0; i < 8; i++) if (v[8+i]) return b >> (i + 1);
    return b;
  endfunction

  function automatic logic [31:0] ref_reg(input logic [31:0] f, input logic [31:0] b, input logic [31:0] prev);
    longint p, d, lf, lb;
    lf = longint'(f); lb = longint'(b);
    p = 2;
    while (lf < lb / (p * 16)) p = p * 2;
    d = 1;
    while (lf < lb / (p * d)) d = d + 1;
    return {prev[31:16], 8'(p / 2), 4'(d - 1), prev[3:1], 1'b1};
  endfunction

  function automatic logic [15:0] exp_rd(input logic [15:0] c, input logic s);
    return c | 16'h0005 | {14'b0, s, 1'b0};
  endfunction

  // driver: offers one write, pushes expected item for enabled writes
  task automatic put(input logic [15:0] v, input bit v3, input logic [31:0] b);
    logic [31:0] f;
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_data = v; v3_mode = v3; base_hz = b; wr_valid = 1'b1;
    mcache = v & 16'hFFC0;
    if (v[2]) begin
      f = ref_freq(b, v3, v);
      mreg = ref_reg(f, b, mreg);
      q_reg.push_back(mreg); q_freq.push_back(f); q_base.push_back(b); q_v3.push_back(v3);
    end else if (!v3) begin
      mreg[3] = 1'b0;
    end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (!wr_ready || q_reg.size() != 0) @(negedge clk);
  endtask

  // monitor: pops expected items when the design reports an update
  always @(negedge clk) begin
    if (rst_n && upd_done) begin
      if (q_reg.size() == 0) begin
        chk(1'b0, "R6 unexpected update", clk_reg, mreg);
      end else begin
        logic [31:0] e, f, b;
        bit m3;
        longint p, d;
        e = q_reg.pop_front(); f = q_freq.pop_front(); b = q_base.pop_front(); m3 = q_v3.pop_front();
        chk(clk_reg[15:8] == e[15:8], m3 ? "R3/R4 prescale" : "R2/R4 prescale", clk_reg, e);
        chk(clk_reg[7:4] == e[7:4], m3 ? "R3/R5 divisor" : "R2/R5 divisor", clk_reg, e);
        chk({clk_reg[31:16], clk_reg[3:0]} == {e[31:16], e[3:0]}, "R6 other bits", clk_reg, e);
        p = longint'(clk_reg[15:8]) * 2;
        d = longint'(clk_reg[7:4]) + 1;
        if (p != 0) chk(longint'(b) / (p * d) <= longint'(f), "R5 bound", clk_reg, f);
      end
    end
  end

  logic [31:0] bases [7] = '{32'd0, 32'd1, 32'd24_000_000, 32'd198_000_000,
                             32'd50_000_001, 32'd400_003, 32'hFFFF_FFFF};
  logic [7:0]  v2b [11] = '{8'h00, 8'h01, 8'h02, 8'h04, 8'h08, 8'h10,
                            8'h20, 8'h40, 8'h80, 8'h06, 8'hFF};
  logic [9:0]  v3n [9]  = '{10'd0, 10'd1, 10'd2, 10'd3, 10'd5, 10'h080,
                            10'h100, 10'h200, 10'h3FF};

  bit timeout = 1'b0;

  initial begin
    mreg = RST_VAL;
    mcache = '0;
    fork
      begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(clk_reg == RST_VAL, "R1 clk_reg", clk_reg, RST_VAL);
        chk(wr_ready == 1'b1, "R1 ready", 32'(wr_ready), 32'd1);
        chk(upd_done == 1'b0, "R1 done", 32'(upd_done), 32'd0);
        chk(rd_clkctl == 16'h0005, "R1 readback", 32'(rd_clkctl), 32'h5);

        // R7 disabled legacy write
        put(16'h12C0, 1'b0, 32'd24_000_000);
        chk(clk_reg == mreg, "R7 bit3 cleared", clk_reg, mreg);
        chk(upd_done == 1'b0 && wr_ready == 1'b1, "R7 no done, ready", {30'b0, upd_done, wr_ready}, 32'd1);
        chk(rd_clkctl == exp_rd(mcache, 1'b0), "R9 readback disabled", 32'(rd_clkctl), 32'(exp_rd(mcache, 1'b0)));

        // enabled write then R8 disabled extended write
        put(16'h0404, 1'b1, 32'd100_000_000);
        drain();
        put(16'h0100, 1'b1, 32'd100_000_000);
        chk(clk_reg == mreg, "R8 register unchanged", clk_reg, mreg);
        chk(upd_done == 1'b0, "R8 no done", 32'(upd_done), 32'd0);
        clk_stable = 1'b1;
        #1;
        chk(rd_clkctl == exp_rd(mcache, 1'b1), "R9 readback stable", 32'(rd_clkctl), 32'(exp_rd(mcache, 1'b1)));
        clk_stable = 1'b0;

        // R2 / R3 sweeps
        for (int bi = 0; bi < 7; bi++) begin
          for (int vi = 0; vi < 11; vi++) put({v2b[vi], 8'hC4}, 1'b0, bases[bi]);
          for (int ni = 0; ni < 9; ni++) put({v3n[ni][7:0], v3n[ni][9:8], 6'b000100}, 1'b1, bases[bi]);
        end
        drain();
        chk(rd_clkctl == exp_rd(mcache, 1'b0), "R9 readback after sweep", 32'(rd_clkctl), 32'(exp_rd(mcache, 1'b0)));

        // R10 hold-off while busy
        put(16'h0804, 1'b0, 32'd52_000_000);
        wr_data = 16'hFFC4; v3_mode = 1'b1; wr_valid = 1'b1;
        for (int c = 0; c < 5; c++) begin
          @(negedge clk);
          chk(wr_ready == 1'b0, "R10 ready low", 32'(wr_ready), 32'd0);
          chk(rd_clkctl == exp_rd(mcache, 1'b0), "R10 readback held", 32'(rd_clkctl), 32'(exp_rd(mcache, 1'b0)));
        end
        wr_valid = 1'b0;
        drain();
        chk(clk_reg == mreg, "R10 result after hold-off", clk_reg, mreg);
        repeat (3) @(negedge clk);
      end
      begin
        repeat (150000) @(posedge clk);
        timeout = 1'b1;
      end
    join_any
    disable fork;
    if (timeout) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule